// File: doc/BRIEF.md
# UART FIFO Trigger and Interrupt Controller

This block holds the receive and transmit byte queues of one UART channel and raises an interrupt for each direction from programmable fill thresholds. The receive shift logic pushes bytes into the receive queue and the host pops them. The host pushes bytes into the transmit queue and the transmit shift logic pops them. A single control register write port sets the thresholds, a DMA mode flag and a queue enable bit, and it can flush either queue.

The receive interrupt is a level that follows the receive fill count against its threshold. The transmit interrupt is an event flag. It sets when the transmit queue drains below its threshold, or when it drains to empty after a refill that never reached the threshold. It clears when a host push brings the count back to the threshold. Both directions decode their two-bit threshold selects from the same table function. The transmit select is written only while an external enhanced-feature enable input is high.

Top module: `uart_fifo_trig`

## Requirements
- R1: After reset both counts are 0, both interrupts and both overrun flags are 0, `dma_mode` is 0 and `fcr_q` reads 0x00.
- R2: Each queue returns bytes in push order, and its count rises by one for each accepted push and falls by one for each accepted pop. A popped byte appears on the read data port after the clock edge that accepts the pop.
- R3: A push into a full queue (count equal to DEPTH) is dropped, the count stays at DEPTH, and that queue's overrun flag sets and stays set.
- R4: A pop from an empty queue leaves the count at 0 and the read data unchanged.
- R5: In a control write, bit 1 flushes the receive queue and bit 2 flushes the transmit queue, but only when bit 0 of the same write is 1. A flush sets the count to 0 and clears that queue's overrun flag. `fcr_q` bits 2:1 always read 0.
- R6: A flush leaves that queue's read data register (the byte last handed to the host or to the shift logic) unchanged.
- R7: Control bit 3 is stored as `dma_mode` and is reflected in `fcr_q` bit 3.
- R8: Control bits 7:6 select the receive threshold: 00=8, 01=16, 10=56, 11=60. `rx_irq` is 1 exactly when the receive count is at or above the threshold.
- R9: Control bits 5:4 select the transmit threshold: 00=8, 01=16, 10=32, 11=56. They are written only when `enh_en` is 1; otherwise they keep their old value. `fcr_q` returns rx select in 7:6, tx select in 5:4, dma in 3 and enable in 0.
- R10: `tx_irq` sets when a pop moves the transmit count from at or above the threshold to below it.
- R11: `tx_irq` sets when a pop empties the transmit queue and the count has not reached the threshold since it was last empty.
- R12: `tx_irq` clears on a host push that brings the transmit count to the threshold or above. Pushes that leave the count below the threshold do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fcr_we | input | 1 | Control register write strobe |
| fcr_wdata | input | 8 | Control register write data |
| enh_en | input | 1 | Enhanced-feature enable; allows writes of the transmit threshold select |
| fcr_q | output | 8 | Control register readback |
| dma_mode | output | 1 | Stored DMA mode flag |
| rx_push | input | 1 | Push from the receive shift logic |
| rx_wdata | input | DW | Receive byte to push |
| rx_pop | input | 1 | Host pop from the receive queue |
| rx_rdata | output | DW | Last byte popped from the receive queue |
| rx_count | output | $clog2(DEPTH)+1 | Receive fill count |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| rx_irq | output | 1 | Receive threshold interrupt |
| tx_push | input | 1 | Host push into the transmit queue |
| tx_wdata | input | DW | Transmit byte to push |
| tx_pop | input | 1 | Pop to the transmit shift logic |
| tx_rdata | output | DW | Last byte popped from the transmit queue |
| tx_count | output | $clog2(DEPTH)+1 | Transmit fill count |
| tx_overrun | output | 1 | Sticky transmit overrun flag |
| tx_irq | output | 1 | Transmit threshold interrupt |

## Verification
The bound checker checks on every cycle that the counts stay within the queue depth, that the overrun flag is sticky until a flush, and that an empty pop changes nothing. It also checks that a control write without the enable bit never moves the receive count, that `rx_irq` matches the count against the threshold decoded from the readback, and that a push reaching the transmit threshold drops `tx_irq`. Only the directed scenarios can show byte order, the exact value of each table entry, the gating of the transmit select by `enh_en`, and the two different ways the transmit interrupt sets. The scenarios also show that a flush leaves the read data registers alone.

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fcr_we,
  input  logic [7:0]                 fcr_wdata,
  input  logic                       enh_en,
  output logic [7:0]                 fcr_q,
  output logic                       dma_mode,
  input  logic                       rx_push,
  input  logic [DW-1:0]              rx_wdata,
  input  logic                       rx_pop,
  output logic [DW-1:0]              rx_rdata,
  output logic [$clog2(DEPTH):0]     rx_count,
  output logic                       rx_overrun,
  output logic                       rx_irq,
  input  logic                       tx_push,
  input  logic [DW-1:0]              tx_wdata,
  input  logic                       tx_pop,
  output logic [DW-1:0]              tx_rdata,
  output logic [$clog2(DEPTH):0]     tx_count,
  output logic                       tx_overrun,
  output logic                       tx_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  function automatic logic [CW-1:0] level(input logic is_tx, input logic [1:0] s);
    case (s)
      2'd0:    level = CW'(8);
      2'd1:    level = CW'(16);
      2'd2:    level = is_tx ? CW'(32) : CW'(56);
      default: level = is_tx ? CW'(56) : CW'(60);
    endcase
  endfunction

  logic          en_q, tx_armed;
  logic [1:0]    rx_sel, tx_sel;
  logic [DW-1:0] rx_mem [DEPTH];
  logic [DW-1:0] tx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp, tx_wp, tx_rp;

  wire [CW-1:0] rx_trig = level(1'b0, rx_sel);
  wire [CW-1:0] tx_trig = level(1'b1, tx_sel);

  wire rx_clr = fcr_we & fcr_wdata[0] & fcr_wdata[1];
  wire tx_clr = fcr_we & fcr_wdata[0] & fcr_wdata[2];
  wire rx_wr  = rx_push & (rx_count != FULL);
  wire rx_rd  = rx_pop  & (rx_count != '0);
  wire tx_wr  = tx_push & (tx_count != FULL);
  wire tx_rd  = tx_pop  & (tx_count != '0);

  wire [CW-1:0] rx_cnt_n = rx_clr ? '0 : rx_count + CW'(rx_wr) - CW'(rx_rd);
  wire [CW-1:0] tx_cnt_n = tx_clr ? '0 : tx_count + CW'(tx_wr) - CW'(tx_rd);

  assign fcr_q  = {rx_sel, tx_sel, dma_mode, 2'b00, en_q};
  assign rx_irq = rx_count >= rx_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; dma_mode <= 1'b0; rx_sel <= 2'd0; tx_sel <= 2'd0;
    end else if (fcr_we) begin
      en_q     <= fcr_wdata[0];
      dma_mode <= fcr_wdata[3];
      rx_sel   <= fcr_wdata[7:6];
      if (enh_en) tx_sel <= fcr_wdata[5:4];
    end
  end

  always_ff @(posedge clk) begin
    if (rx_wr && !rx_clr) rx_mem[rx_wp] <= rx_wdata;
    if (tx_wr && !tx_clr) tx_mem[tx_wp] <= tx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_count <= '0; rx_overrun <= 1'b0; rx_rdata <= '0;
    end else begin
      rx_count <= rx_cnt_n;
      if (rx_rd) rx_rdata <= rx_mem[rx_rp];
      if (rx_clr) begin
        rx_wp <= '0; rx_rp <= '0; rx_overrun <= 1'b0;
      end else begin
        if (rx_wr) rx_wp <= rx_wp + 1'b1;
        if (rx_rd) rx_rp <= rx_rp + 1'b1;
        if (rx_push && !rx_wr) rx_overrun <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_count <= '0; tx_overrun <= 1'b0; tx_rdata <= '0;
    end else begin
      tx_count <= tx_cnt_n;
      if (tx_rd) tx_rdata <= tx_mem[tx_rp];
      if (tx_clr) begin
        tx_wp <= '0; tx_rp <= '0; tx_overrun <= 1'b0;
      end else begin
        if (tx_wr) tx_wp <= tx_wp + 1'b1;
        if (tx_rd) tx_rp <= tx_rp + 1'b1;
        if (tx_push && !tx_wr) tx_overrun <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_armed <= 1'b0; tx_irq <= 1'b0;
    end else if (tx_clr) begin
      tx_armed <= 1'b0; tx_irq <= 1'b0;
    end else begin
      if (tx_cnt_n >= tx_trig)  tx_armed <= 1'b1;
      else if (tx_cnt_n == '0)  tx_armed <= 1'b0;
      if (tx_wr && tx_cnt_n >= tx_trig)
        tx_irq <= 1'b0;
      else if ((tx_count >= tx_trig && tx_cnt_n < tx_trig) ||
               (!tx_armed && tx_count != '0 && tx_cnt_n == '0))
        tx_irq <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_fifo_trig_chk.sv
module uart_fifo_trig_chk #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   fcr_we,
  input logic [7:0]             fcr_wdata,
  input logic [7:0]             fcr_q,
  input logic                   rx_push,
  input logic                   rx_pop,
  input logic [DW-1:0]          rx_rdata,
  input logic [$clog2(DEPTH):0] rx_count,
  input logic                   rx_overrun,
  input logic                   rx_irq,
  input logic                   tx_push,
  input logic                   tx_pop,
  input logic [$clog2(DEPTH):0] tx_count,
  input logic                   tx_irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  function automatic logic [CW-1:0] rx_thr(input logic [1:0] s);
    rx_thr = (s == 2'd3) ? CW'(60) : (s == 2'd2) ? CW'(56) : (s == 2'd1) ? CW'(16) : CW'(8);
  endfunction
  function automatic logic [CW-1:0] tx_thr(input logic [1:0] s);
    tx_thr = (s == 2'd3) ? CW'(56) : (s == 2'd2) ? CW'(32) : (s == 2'd1) ? CW'(16) : CW'(8);
  endfunction

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH) && tx_count <= CW'(DEPTH));

  a_r3_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun && !(fcr_we && fcr_wdata[0] && fcr_wdata[1]) |=> rx_overrun);

  a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop && rx_count == '0 && !rx_push && !fcr_we |=> $stable(rx_rdata) && rx_count == '0);

  a_r5_no_flush_without_en: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_we && !fcr_wdata[0] && !rx_push && !rx_pop |=> $stable(rx_count));

  a_r8_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq == (rx_count >= rx_thr(fcr_q[7:6])));

  a_r12_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push && !tx_pop && !fcr_we && tx_count < CW'(DEPTH) &&
    (tx_count + 1'b1) >= tx_thr(fcr_q[5:4]) |=> !tx_irq);
endmodule

bind uart_fifo_trig uart_fifo_trig_chk #(.DEPTH(DEPTH), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata), .fcr_q(fcr_q),
  .rx_push(rx_push), .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_count(rx_count),
  .rx_overrun(rx_overrun), .rx_irq(rx_irq), .tx_push(tx_push), .tx_pop(tx_pop),
  .tx_count(tx_count), .tx_irq(tx_irq)
);

// File: tb/test_uart_fifo_trig.sv
module test_uart_fifo_trig;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fcr_we = 1'b0, enh_en = 1'b0;
  logic [7:0] fcr_wdata = '0;
  logic rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
  logic [7:0] rx_wdata = '0, tx_wdata = '0;
  logic [7:0] fcr_q, rx_rdata, tx_rdata;
  logic [6:0] rx_count, tx_count;
  logic dma_mode, rx_overrun, rx_irq, tx_overrun, tx_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_fifo_trig i_uart_fifo_trig (
    .clk(clk), .rst_n(rst_n), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata), .enh_en(enh_en),
    .fcr_q(fcr_q), .dma_mode(dma_mode),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_count(rx_count), .rx_overrun(rx_overrun), .rx_irq(rx_irq),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .tx_count(tx_count), .tx_overrun(tx_overrun), .tx_irq(tx_irq));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic enh);
    @(negedge clk); fcr_we = 1; fcr_wdata = d; enh_en = enh;
    @(negedge clk); fcr_we = 0; enh_en = 0;
  endtask
  task automatic rpush(input logic [7:0] d);
    @(negedge clk); rx_push = 1; rx_wdata = d; @(negedge clk); rx_push = 0;
  endtask
  task automatic rpop();
    @(negedge clk); rx_pop = 1; @(negedge clk); rx_pop = 0;
  endtask
  task automatic tpush(input logic [7:0] d);
    @(negedge clk); tx_push = 1; tx_wdata = d; @(negedge clk); tx_push = 0;
  endtask
  task automatic tpop();
    @(negedge clk); tx_pop = 1; @(negedge clk); tx_pop = 0;
  endtask

  task automatic t_reset();
    check("R1 rx_count", rx_count, 0);
    check("R1 tx_count", tx_count, 0);
    check("R1 irqs", {rx_irq, tx_irq}, 0);
    check("R1 overruns", {rx_overrun, tx_overrun}, 0);
    check("R1 dma", dma_mode, 0);
    check("R1 fcr_q", fcr_q, 8'h00);
  endtask

  task automatic t_order();
    rpush(8'hA1); rpush(8'hB2); rpush(8'hC3);
    check("R2 count", rx_count, 3);
    rpop(); check("R2 first", rx_rdata, 8'hA1);
    rpop(); check("R2 second", rx_rdata, 8'hB2);
    check("R2 count after pops", rx_count, 1);
  endtask

  task automatic t_rx_trig();
    int lv[4] = '{8, 16, 56, 60};
    for (int s = 0; s < 4; s++) begin
      wr(8'((s << 6) | 3), 1'b0);
      check("R8 flushed", rx_count, 0);
      for (int i = 0; i < lv[s] - 1; i++) rpush(8'(i));
      check("R8 below level", rx_irq, 0);
      rpush(8'hFF);
      check("R8 at level", rx_irq, 1);
    end
    rpop();
    check("R8 drops below", rx_irq, 0);
    rpush(8'h55);
  endtask

  task automatic t_fifo_reset();
    logic [7:0] d;
    wr(8'hC6, 1'b0);
    check("R5 no flush without bit0", rx_count, 60);
    rpop(); d = rx_rdata;
    wr(8'hC7, 1'b0);
    check("R5 rx flushed", rx_count, 0);
    check("R5 readback bits 2:1", fcr_q[2:1], 0);
    check("R6 rx_rdata kept", rx_rdata, d);
  endtask

  task automatic t_full();
    wr(8'h03, 1'b0);
    for (int i = 0; i < 64; i++) rpush(8'(i + 1));
    check("R3 full count", rx_count, 64);
    check("R3 no overrun yet", rx_overrun, 0);
    rpush(8'hEE);
    check("R3 count stays", rx_count, 64);
    check("R3 overrun set", rx_overrun, 1);
    for (int i = 0; i < 64; i++) begin
      rpop();
      if (rx_rdata != 8'(i + 1)) check("R3 drained data", rx_rdata, i + 1);
    end
    check("R3 last data", rx_rdata, 64);
    check("R3 overrun sticky", rx_overrun, 1);
  endtask

  task automatic t_empty();
    rpop();
    check("R4 count stays 0", rx_count, 0);
    check("R4 data unchanged", rx_rdata, 64);
    wr(8'h03, 1'b0);
    check("R5 flush clears overrun", rx_overrun, 0);
  endtask

  task automatic t_dma();
    wr(8'h09, 1'b0);
    check("R7 dma set", dma_mode, 1);
    check("R7 fcr_q bit3", fcr_q[3], 1);
    wr(8'h01, 1'b0);
    check("R7 dma clear", dma_mode, 0);
  endtask

  task automatic t_tx_sel();
    wr(8'h31, 1'b0);
    check("R9 gated tx sel", fcr_q, 8'h01);
    wr(8'h31, 1'b1);
    check("R9 tx sel written", fcr_q, 8'h31);
    wr(8'h21, 1'b1);
    for (int i = 0; i < 32; i++) tpush(8'(i));
    check("R9 tx level 32 no irq", tx_irq, 0);
    tpop();
    check("R9 tx below 32", tx_irq, 1);
    check("R2 tx first byte", tx_rdata, 0);
    wr(8'h81, 1'b0);
    check("R9 rx sel only", fcr_q, 8'hA1);
  endtask

  task automatic t_tx_fall();
    wr(8'h05, 1'b1);
    check("R5 tx flushed", tx_count, 0);
    check("R5 tx irq cleared", tx_irq, 0);
    for (int i = 0; i < 10; i++) tpush(8'(i + 16));
    check("R10 above level", tx_irq, 0);
    tpop(); tpop();
    check("R10 at level", tx_irq, 0);
    tpop();
    check("R10 fell below", tx_irq, 1);
    check("R2 tx order", tx_rdata, 18);
    tpush(8'h77);
    check("R12 push to level clears", tx_irq, 0);
  endtask

  task automatic t_tx_empty();
    logic [7:0] d;
    wr(8'h05, 1'b1);
    tpush(8'h11); tpush(8'h22); tpush(8'h33);
    check("R11 short load no irq", tx_irq, 0);
    tpop(); tpop();
    check("R11 not yet empty", tx_irq, 0);
    tpop();
    check("R11 empty irq", tx_irq, 1);
    d = tx_rdata;
    tpush(8'h44);
    check("R12 push below level keeps irq", tx_irq, 1);
    wr(8'h05, 1'b1);
    check("R6 tx_rdata kept", tx_rdata, d);
    check("R5 tx count flushed", tx_count, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_rx_trig();
    t_fifo_reset();
    t_full();
    t_empty();
    t_dma();
    t_tx_sel();
    t_tx_fall();
    t_tx_empty();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule